// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two unsigned operands and a single-bit carry input. It returns a sum as wide as the operands, a carry output and an unsigned overflow flag. There are no registers and no clock. The outputs settle from the inputs within a fixed depth of logic, and that depth does not grow with the operand width the way a ripple chain does.

The datapath is split into 4-bit groups. Inside a group, each bit forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). The XOR that forms the propagate term is also the XOR that forms the sum. Each carry inside the group is a flat AND-OR of these terms. Each group also reports a group generate and a group propagate. A second lookahead level turns these into the carry into every group, again as a flat AND-OR, so no carry passes serially from one group to the next. The carry input enters at the least significant bit. Wider adders can therefore be chained from this one.

The operand width is a parameter and must be a multiple of four. Any other value stops elaboration.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of the arithmetic value a + b + cin.
- R2: `cout` equals bit WIDTH of a + b + cin, which is the carry out of the most significant bit.
- R3: `ovf` is 1 exactly when the unsigned result does not fit in WIDTH bits, and it always equals `cout`.
- R4: With a all ones, b zero and cin = 1, the carry input passes through every group: `sum` is zero and `cout` is 1.
- R5: When every bit position propagates (b is the bitwise inverse of a) and cin = 0, no carry arises anywhere: `sum` is all ones and `cout` is 0.
- R6: A carry produced in one group reaches the next group. For example, 0x000F + 0x0001 gives 0x0010, and a carry produced at bit 0 with every other bit propagating gives a zero sum with `cout` = 1.
- R7: A single-group configuration (WIDTH = 4) gives the correct sum, carry and overflow for all 512 combinations of a, b and cin.
- R8: The outputs depend only on the present inputs. A new result is visible after an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into the least significant bit |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the most significant bit |
| ovf | output | 1 | Unsigned overflow, same as cout |

## Verification
The hardest case to reach from the ports is the longest carry path. A carry must begin at bit 0, or at the carry input, and every group above it must be in full propagate, so the second lookahead level alone decides the top carry. Random operands almost never give this pattern. The stimulus therefore drives it directly: all-ones operands against zero or one, complementary and alternating patterns, and single-group boundary values. A full sweep of a one-group instance covers every combination of generate and propagate inside a group.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int GROUP_W  = 4;
    localparam int MAX_GRPS = 64;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    function automatic logic [MAX_GRPS-1:0] span_mask(input int lo, input int hi);
        logic [MAX_GRPS-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_GRPS; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    // Generate and propagate are mutually exclusive by this choice of propagate.
    assign gen  = a & b;
    assign prop = a ^ b;
endmodule

// File: rtl/cla_group4.sv
module cla_group4
    import cla_pkg::*;
(
    input  logic [GROUP_W-1:0] gen,
    input  logic [GROUP_W-1:0] prop,
    input  logic               cin,
    output logic [GROUP_W-1:0] sum,
    output gp_t                grp
);
    logic [GROUP_W-1:0] c;

    // Flat two-level carry terms inside the group
    always_comb begin
        c[0] = cin;
        c[1] = gen[0] | (prop[0] & cin);
        c[2] = gen[1] | (prop[1] & gen[0]) | (prop[1] & prop[0] & cin);
        c[3] = gen[2] | (prop[2] & gen[1]) | (prop[2] & prop[1] & gen[0])
             | (prop[2] & prop[1] & prop[0] & cin);
    end

    // The propagate XOR is reused for the sum
    assign sum = prop ^ c;

    assign grp.gen  = gen[3] | (prop[3] & gen[2]) | (prop[3] & prop[2] & gen[1])
                    | (prop[3] & prop[2] & prop[1] & gen[0]);
    assign grp.prop = &prop;
endmodule

// File: rtl/cla_group_carry.sv
module cla_group_carry
    import cla_pkg::*;
#(
    parameter int NGRP = 4
) (
    input  logic [NGRP-1:0] grp_gen,
    input  logic [NGRP-1:0] grp_prop,
    input  logic            cin,
    output logic [NGRP:0]   gcarry
);
    assign gcarry[0] = cin;

    for (genvar k = 1; k <= NGRP; k++) begin : g_carry
        logic [k:0] terms;
        // Term from the carry input: every group below k propagates.
        localparam logic [MAX_GRPS-1:0] CMASK = span_mask(0, k - 1);
        assign terms[k] = cin & (&(grp_prop | ~CMASK[NGRP-1:0]));
        for (genvar j = 0; j < k; j++) begin : g_term
            // Group j generates, and every group from j+1 to k-1 propagates.
            localparam logic [MAX_GRPS-1:0] JMASK = span_mask(j + 1, k - 1);
            assign terms[j] = grp_gen[j] & (&(grp_prop | ~JMASK[NGRP-1:0]));
        end
        assign gcarry[k] = |terms;
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int NGRP = WIDTH / GROUP_W;

    if ((WIDTH % GROUP_W) != 0 || WIDTH < GROUP_W || NGRP > MAX_GRPS) begin : g_bad_width
        $error("cla_adder: WIDTH must be a positive multiple of 4, at most 256");
    end

    logic [WIDTH-1:0] bit_gen;
    logic [WIDTH-1:0] bit_prop;
    logic [NGRP-1:0]  grp_gen;
    logic [NGRP-1:0]  grp_prop;
    logic [NGRP:0]    gcarry;

    cla_bit_gp #(.WIDTH(WIDTH)) u_gp (
        .a    (a),
        .b    (b),
        .gen  (bit_gen),
        .prop (bit_prop)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        gp_t grp;
        cla_group4 u_grp (
            .gen  (bit_gen[k*GROUP_W +: GROUP_W]),
            .prop (bit_prop[k*GROUP_W +: GROUP_W]),
            .cin  (gcarry[k]),
            .sum  (sum[k*GROUP_W +: GROUP_W]),
            .grp  (grp)
        );
        assign grp_gen[k]  = grp.gen;
        assign grp_prop[k] = grp.prop;
    end

    cla_group_carry #(.NGRP(NGRP)) u_gcarry (
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop),
        .cin      (cin),
        .gcarry   (gcarry)
    );

    assign cout = gcarry[NGRP];
    assign ovf  = gcarry[NGRP];
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             ovf
);
    logic [WIDTH:0] ref_full;
    assign ref_full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

    always_comb begin
        a_r1_sum: assert (sum == ref_full[WIDTH-1:0]);
        a_r2_cout: assert (cout == ref_full[WIDTH]);
        a_r3_no_overflow: assert (ovf == (ref_full > {1'b0, {WIDTH{1'b1}}}));
        a_r4_cin_chain: assert (!((&a) && (b == '0) && cin) || (sum == '0 && cout));
        a_r5_no_gen: assert (!((&(a ^ b)) && !cin) || ((&sum) && !cout));
    end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .sum  (sum),
    .cout (cout),
    .ovf  (ovf)
);

// File: tb/cla_adder_tb.sv
module cla_adder_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b, sum;
    logic         cin, cout, ovf;
    logic [3:0]   a4, b4, sum4;
    logic         cin4, cout4, ovf4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    cla_adder #(.WIDTH(W)) u_dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    cla_adder #(.WIDTH(4)) u_dut4 (
        .a(a4), .b(b4), .cin(cin4), .sum(sum4), .cout(cout4), .ovf(ovf4)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one vector to the wide instance and check the R1, R2 and R3 outputs.
    task automatic run16(input string tag, input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c);
        logic [W:0] e;
        @(negedge clk);
        a = x; b = y; cin = c;
        #1;
        e = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        chk({tag, " R1 sum"},  32'(sum),  32'(e[W-1:0]));
        chk({tag, " R2 cout"}, 32'(cout), 32'(e[W]));
        chk({tag, " R3 ovf"},  32'(ovf),  32'(e > {1'b0, {W{1'b1}}}));
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        a4 = '0; b4 = '0; cin4 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Inputs at zero: outputs at zero
        chk("R1 zero sum", 32'(sum), 32'h0);
        chk("R2 zero cout", 32'(cout), 32'h0);

        // R4: the carry input passes through all groups
        run16("R4", 16'hFFFF, 16'h0000, 1'b1);
        chk("R4 sum zero", 32'(sum), 32'h0);
        chk("R4 cout set", 32'(cout), 32'h1);

        // R5: every bit propagates, nothing generates
        run16("R5 a", 16'hA5C3, 16'h5A3C, 1'b0);
        chk("R5 sum ones", 32'(sum), 32'hFFFF);
        chk("R5 cout clear", 32'(cout), 32'h0);
        run16("R5 b", 16'hAAAA, 16'h5555, 1'b0);
        run16("R5 b cin", 16'hAAAA, 16'h5555, 1'b1);

        // R6: a carry crossing group boundaries
        run16("R6 grp", 16'h000F, 16'h0001, 1'b0);
        chk("R6 grp sum", 32'(sum), 32'h0010);
        run16("R6 mid", 16'h00FF, 16'h0001, 1'b0);
        run16("R6 long", 16'h0001, 16'hFFFF, 1'b0);
        chk("R6 long sum", 32'(sum), 32'h0);
        chk("R6 long cout", 32'(cout), 32'h1);
        run16("R6 top", 16'h0FFF, 16'hF001, 1'b0);

        // Corner vectors for R1, R2 and R3
        run16("R1 ones", 16'hFFFF, 16'hFFFF, 1'b0);
        run16("R1 ones cin", 16'hFFFF, 16'hFFFF, 1'b1);
        run16("R1 zeros cin", 16'h0000, 16'h0000, 1'b1);
        run16("R1 alt", 16'hAAAA, 16'hAAAA, 1'b1);
        run16("R1 alt2", 16'h5555, 16'h5555, 1'b0);
        run16("R3 edge", 16'h8000, 16'h8000, 1'b0);
        run16("R3 noedge", 16'h7FFF, 16'h8000, 1'b0);

        // Random vectors for R1, R2 and R3
        for (int i = 0; i < 2000; i++) begin
            run16("R1 rnd", 16'($urandom), 16'($urandom), 1'($urandom));
        end

        // R8: a new result appears with no clock edge in between
        @(negedge clk);
        a = 16'h1234; b = 16'h1111; cin = 1'b0;
        #0.5;
        chk("R8 settle1", 32'(sum), 32'h2345);
        a = 16'h2000; b = 16'h0002; cin = 1'b1;
        #0.5;
        chk("R8 settle2", 32'(sum), 32'h2003);

        // R7: full sweep of the single-group instance
        for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
                for (int c = 0; c < 2; c++) begin
                    int e;
                    @(negedge clk);
                    a4 = 4'(x); b4 = 4'(y); cin4 = 1'(c);
                    #1;
                    e = x + y + c;
                    chk("R7 sum4", 32'(sum4), 32'(e % 16));
                    chk("R7 cout4", 32'(cout4), 32'(e / 16));
                    chk("R7 ovf4", 32'(ovf4), 32'(e > 15));
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule